// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block is a general-purpose I/O port sitting on a simple single-cycle register bus. Software picks, pin by pin, whether a pin drives the pad or listens to it, sets the level each output drives, and reads the synchronised level of every pad back. On a pin configured as an input, the same output-register bit no longer drives the pad. It decides whether the pad floats or gets a weak pull-up.

Every input pin can also raise an interrupt. A per-pin select bit picks the rising or the falling edge. A detected edge sets a sticky flag, which software clears by writing 1 to it. A per-pin enable bit gates each flag onto a single interrupt request line. One bit position can be built as non-functional through a parameter mask. That bit then reads as zero everywhere, ignores writes, drives nothing and never flags.

Top module: `gpio_irq_port`

## Requirements
- R1: A pin whose direction bit is 1 is an output. `pad_oe` equals the direction register, and `pad_out` carries the output-register bit on output pins and 0 on input pins.
- R2: On a pin whose direction bit is 0, `pad_pull` equals the output-register bit (0 = high impedance, 1 = weak pull-up). `pad_pull` is 0 on output pins.
- R3: The input register (address 1) returns the pad levels after a two-flop synchroniser. It is read-only, and writes to it change nothing.
- R4: A flag bit is set when its pin is an input and the selected edge occurs on its synchronised level. Edge-select bit 0 means rising and 1 means falling. The flag is set whatever the enable bit holds. A pad change made just after clock edge k shows in the flag register after edge k+3.
- R5: Writing 1 to a bit of the flag register (address 4) clears that flag, and writing 0 leaves it unchanged. If an edge sets a flag in the same cycle as a clear, the flag stays set.
- R6: `irq` is the OR over all pins of flag AND enable.
- R7: A pin configured as an output never sets its flag.
- R8: The bit position named in `DEAD_MASK` (default bit 7) reads 0 in every register. Writes to it are ignored, it drives 0 on `pad_oe`, `pad_out` and `pad_pull`, and it never sets a flag.
- R9: After reset every pin is an input with high impedance, and the out, direction, enable, flag and edge-select registers are all 0. `irq` is 0.
- R10: The register map is: 0 out, 1 in, 2 direction, 3 enable, 4 flag, 5 edge select. Addresses 6 and 7 read 0. `bus_rdata` is registered, so it shows the register chosen at a clock edge right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad levels, asynchronous |
| pad_oe | output | 8 | Output enable per pin |
| pad_out | output | 8 | Output level per pin |
| pad_pull | output | 8 | Weak pull-up enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus address, write enable and write data are always at known levels, and that reset is asserted from time zero. The flag properties assume that a pad level, once changed, stays long enough for the synchroniser to capture it.

The stimulus respects these limits in several ways:
- It drives every bus input at a defined value on the falling clock edge.
- It holds each random pad pattern for several cycles before reading the flags.
- It changes direction and edge-select only while the pads are stable, so a reconfiguration never creates a false edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT  = 3'd0,
    REG_IN   = 3'd1,
    REG_DIR  = 3'd2,
    REG_IEN  = 3'd3,
    REG_FLAG = 3'd4,
    REG_EDGE = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] dly_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      dly_q  <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign dly_o  = dly_q;
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int           W    = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] dly_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] edge_sel_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (LIVE[i]) begin : g_live
      logic rise;
      logic fall;
      logic hit;
      logic flag_q;

      assign rise = sync_i[i] & ~dly_i[i];
      assign fall = ~sync_i[i] & dly_i[i];
      assign hit  = ~dir_i[i] & (edge_sel_i[i] ? fall : rise);

      always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (clr_i[i]) flag_q <= 1'b0;
      end

      assign flag_o[i] = flag_q;
    end else begin : g_dead
      assign flag_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int           W    = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      in_val,
  input  logic [W-1:0]      flag,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      edge_q,
  output logic [W-1:0]      clr_mask
);
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;
  logic [W-1:0] wmask;
  reg_sel_e     sel;

  assign sel   = reg_sel_e'(addr);
  assign wmask = wdata & LIVE;

  always_comb begin
    case (sel)
      REG_OUT:  rd_mux = out_q;
      REG_IN:   rd_mux = in_val & LIVE;
      REG_DIR:  rd_mux = dir_q;
      REG_IEN:  rd_mux = ien_q;
      REG_FLAG: rd_mux = flag;
      REG_EDGE: rd_mux = edge_q;
      default:  rd_mux = '0;
    endcase
  end

  assign clr_mask = (we && sel == REG_FLAG) ? wmask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      edge_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (we) begin
        case (sel)
          REG_OUT:  out_q  <= wmask;
          REG_DIR:  dir_q  <= wmask;
          REG_IEN:  ien_q  <= wmask;
          REG_EDGE: edge_q <= wmask;
          default:  ;
        endcase
      end
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] DEAD_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pull,
  output logic              irq
);
  localparam logic [W-1:0] LIVE = ~DEAD_MASK;

  logic [W-1:0] sync_v;
  logic [W-1:0] dly_v;
  logic [W-1:0] out_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] ien_q;
  logic [W-1:0] edge_q;
  logic [W-1:0] clr_mask;
  logic [W-1:0] flag_q;

  gpio_in_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pad_in (pad_in),
    .sync_o (sync_v),
    .dly_o  (dly_v)
  );

  gpio_regfile #(.W(W), .LIVE(LIVE)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .in_val   (sync_v),
    .flag     (flag_q),
    .rdata    (bus_rdata),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .ien_q    (ien_q),
    .edge_q   (edge_q),
    .clr_mask (clr_mask)
  );

  gpio_edge_flags #(.W(W), .LIVE(LIVE)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .sync_i     (sync_v),
    .dly_i      (dly_v),
    .dir_i      (dir_q),
    .edge_sel_i (edge_q),
    .clr_i      (clr_mask),
    .flag_o     (flag_q)
  );

  assign pad_oe   = dir_q;
  assign pad_out  = out_q & dir_q;
  assign pad_pull = out_q & ~dir_q;
  assign irq      = |(flag_q & ien_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int           W         = 8,
  parameter logic [W-1:0] DEAD_MASK = 8'h80
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   bus_addr,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_pull,
  input logic         irq,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] ien_q,
  input logic [W-1:0] dir_q
);
  logic [W-1:0] clr_seen;
  assign clr_seen = (bus_we && bus_addr == 3'd4) ? bus_wdata : '0;

  AST_NO_PULL_ON_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (pad_pull & pad_oe) == '0);  // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flag_q) & ~$past(clr_seen) & ~flag_q) == '0));  // R5

  AST_NO_FLAG_ON_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & $past(dir_q)) == '0));  // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |-> !irq);  // R6

  AST_DEAD_BIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | pad_out | pad_pull | bus_rdata | flag_q) & DEAD_MASK) == '0);  // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_pull == '0 && flag_q == '0 && !irq));  // R9
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W), .DEAD_MASK(DEAD_MASK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pull  (pad_pull),
  .irq       (irq),
  .flag_q    (flag_q),
  .ien_q     (ien_q),
  .dir_q     (dir_q)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam int         W    = 8;
  localparam logic [7:0] DEAD = 8'h80;
  localparam logic [7:0] LIVE = ~DEAD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;
  logic [7:0] pad_pull;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_irq_port #(.W(W), .DEAD_MASK(DEAD)) u_gpio_irq_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull), .irq(irq)
  );

  function automatic logic [7:0] exp_flags(logic [7:0] old_p, logic [7:0] new_p,
                                           logic [7:0] dir, logic [7:0] edg);
    logic [7:0] rise = ~old_p & new_p;
    logic [7:0] fall = old_p & ~new_p;
    return ((rise & ~edg) | (fall & edg)) & ~dir & LIVE;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic set_pad(logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] old_p;
    logic [7:0] dir;
    logic [7:0] edg;
    logic [7:0] ien;
    logic [7:0] outv;
    logic [7:0] ef;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9 reset state
    #1;
    check("R9 pad_oe", pad_oe, 8'h00);
    check("R9 pad_pull", pad_pull, 8'h00);
    check("R9 irq", irq, 1'b0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R9 reg", v, 8'h00);
    end

    // R10 unused addresses, R3 input register read-only
    wr(3'd6, 8'hFF);
    rd(3'd6, v); check("R10 addr6", v, 8'h00);
    rd(3'd7, v); check("R10 addr7", v, 8'h00);
    wr(3'd1, 8'h3C);
    rd(3'd1, v); check("R3 in read-only", v, 8'h00);

    // R8 dead bit, R1 outputs
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd5, 8'hFF);
    rd(3'd0, v); check("R8 out", v, 8'h7F);
    rd(3'd2, v); check("R8 dir", v, 8'h7F);
    rd(3'd3, v); check("R8 ien", v, 8'h7F);
    rd(3'd5, v); check("R8 edge", v, 8'h7F);
    check("R1 pad_oe", pad_oe, 8'h7F);
    check("R1 pad_out", pad_out, 8'h7F);
    check("R2 pull off on outputs", pad_pull, 8'h00);

    // R7 outputs never flag
    set_pad(8'h7F); set_pad(8'h00);
    rd(3'd4, v); check("R7 no flag on outputs", v, 8'h00);
    check("R7 irq", irq, 1'b0);

    // R2 pull-up on inputs, R8 dead bit never flags
    wr(3'd2, 8'h00); wr(3'd5, 8'h00);
    check("R2 pull", pad_pull, 8'h7F);
    check("R1 pad_out on inputs", pad_out, 8'h00);
    set_pad(8'h80);
    rd(3'd4, v); check("R8 dead flag", v, 8'h00);
    rd(3'd1, v); check("R8 dead in", v, 8'h00);
    check("R8 irq", irq, 1'b0);
    set_pad(8'h00);

    // R4 flag timing: visible after edge k+3
    wr(3'd3, 8'h00);
    @(negedge clk) pad_in = 8'h01;
    @(posedge clk); @(posedge clk); #1;
    rd(3'd4, v); check("R4 not yet", v, 8'h00);
    rd(3'd4, v); check("R4 set, enable off", v, 8'h01);
    check("R6 irq masked", irq, 1'b0);
    wr(3'd3, 8'h01);
    #1 check("R6 irq", irq, 1'b1);

    // R5 partial clear
    set_pad(8'h03);
    wr(3'd4, 8'h01);
    rd(3'd4, v); check("R5 partial clear", v, 8'h02);

    // R5 set wins over clear in the same cycle
    wr(3'd4, 8'hFF);
    @(negedge clk) pad_in = 8'h07;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin bus_addr = 3'd4; bus_we = 1'b1; bus_wdata = 8'h04; end
    @(posedge clk);
    @(negedge clk) begin bus_we = 1'b0; bus_wdata = '0; end
    rd(3'd4, v); check("R5 set wins", v, 8'h04);
    wr(3'd4, 8'h04);
    rd(3'd4, v); check("R5 clear", v, 8'h00);

    // random patterns: R1 R2 R3 R4 R6
    old_p = pad_in;
    for (int it = 0; it < 200; it++) begin
      dir  = 8'($urandom);
      edg  = 8'($urandom);
      ien  = 8'($urandom);
      outv = 8'($urandom);
      wr(3'd0, outv); wr(3'd2, dir); wr(3'd5, edg); wr(3'd3, ien);
      wr(3'd4, 8'hFF);
      check("R1 rand oe", pad_oe, dir & LIVE);
      check("R1 rand out", pad_out, outv & dir & LIVE);
      check("R2 rand pull", pad_pull, outv & ~dir & LIVE);
      v = 8'($urandom);
      set_pad(v);
      ef = exp_flags(old_p, v, dir, edg);
      rd(3'd4, v); check("R4 rand flags", v, ef);
      check("R6 rand irq", irq, |(ef & ien & LIVE));
      rd(3'd1, v); check("R3 rand in", v, pad_in & LIVE);
      old_p = pad_in;
    end

    summary();
  end
endmodule